// File: doc/BRIEF.md
# Page-Write Load and Program Controller

This block models, cycle by cycle, the write path of a byte-wide nonvolatile memory. The host presents an active-low chip select, write strobe and read strobe together with a 13-bit address and an 8-bit data byte. Each write cycle loads one byte into a page buffer. The first accepted load fixes the page, which is the address bits above the 6-bit in-page offset. Later loads to that page may arrive in any order and may rewrite an offset. The load phase has no total length limit. It ends when no further load to the page starts within a byte-load window.

When the window runs out, a timed programming phase begins. During that phase the bus does not return array data. A read returns a status byte instead. Its top bit is the inverse of the top bit of the last loaded byte, and bit 6 flips after every read. When the phase ends, every loaded byte is committed to the storage array in one cycle and normal reads resume.

The storage array is a behavioural register array that resets to the erased value FFh. It keeps only the low `MEM_AW` address bits, so higher addresses alias. The byte-load window and the programming time are both parameters counted in clock cycles. Bus inputs are taken to be synchronous to `clk`.

Top module: `pgw_ctrl`

## Requirements
- R1: A cycle counts as a write only when chip select and write strobe are both low and the read strobe is high. `bus_rdata_oe` is high exactly one cycle after a sampled cycle with chip select and read strobe low and write strobe high, and is low otherwise.
- R2: The address of a load is taken in the first cycle of the write condition. The data is taken from the last cycle of the write condition.
- R3: The page of the first load is fixed by address bits [12:6]. A later load with different page bits is ignored: it writes nothing and does not restart the byte-load window.
- R4: A load whose first write cycle comes no more than `WIN_CYC` cycles after the first write cycle of the previous accepted load joins the current page. Any number of such loads may be chained.
- R5: If `WIN_CYC` cycles pass after the last accepted load starts and no new one has started, programming begins. After `PROG_CYC` cycles, every loaded offset of the page is written to the array. Offsets that were not loaded keep their old contents.
- R6: A read sampled while programming returns the last loaded byte with bit 7 inverted and bit 6 replaced by the toggle bit. This also holds for the read sampled on the final programming cycle.
- R7: The toggle bit inverts after every read that ends while programming. Outside programming it does not change.
- R8: Write cycles during programming are ignored and do not change the byte reported in the status.
- R9: After reset, `bus_rdata_oe` is low and every array byte reads FFh. Once programming completes, reads return the stored array data.
- R10: A programmed byte replaces the old value bit for bit in both directions, with no erase step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Read strobe, active low |
| bus_addr | input | 13 | Byte address; bits [12:6] select the page |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data or status byte |
| bus_rdata_oe | output | 1 | Drive enable for the read data; the bus floats when low |

## Verification
A read sampled at one clock edge shows its data after that same edge. The bench therefore samples `bus_rdata` at the falling edge that follows the edge at which the read strobe was taken.

Programming begins at the edge that comes exactly `WIN_CYC` edges after the first write edge of the last accepted load. A read taken at that edge still returns array data, and a read taken two edges later returns the status byte. The array is committed `PROG_CYC` edges after programming begins. A read taken at the commit edge still returns status, and the next read returns the new data.

The bench counts falling edges and places each read on one of these computed edges. This places reads on both sides of each boundary. It also shows whether an ignored load restarted the window, because a restarted window would move the programming start later.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        PGW_IDLE = 2'd0,
        PGW_LOAD = 2'd1,
        PGW_PROG = 2'd2
    } pgw_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } pgw_strb_t;

endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe
    import pgw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_lvl,
    output logic wr_start,
    output logic wr_end,
    output logic wr_held,
    output logic rd_lvl,
    output logic rd_end
);

    pgw_strb_t s_d, s_q;

    // Decode the three strobes into the write and read conditions.
    always_comb begin
        s_d.wr = !ce_n && !we_n && oe_n;
        s_d.rd = !ce_n && !oe_n && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_lvl   = s_d.wr;
    assign wr_start = s_d.wr && !s_q.wr;
    assign wr_end   = !s_d.wr && s_q.wr;
    assign wr_held  = s_q.wr;
    assign rd_lvl   = s_d.rd;
    assign rd_end   = !s_d.rd && s_q.rd;

endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [PAGE_W-1:0]                       wr_off,
    input  logic [DATA_W-1:0]                       wr_data,
    input  logic                                    clr,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]      pg_data,
    output logic [(1<<PAGE_W)-1:0]                  pg_vld
);

    localparam int NB = 1 << PAGE_W;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [DATA_W-1:0] dat_d, dat_q;
        logic              vld_d, vld_q;

        always_comb begin
            dat_d = dat_q;
            vld_d = vld_q;
            if (clr) vld_d = 1'b0;
            if (wr_en && (wr_off == PAGE_W'(g))) begin
                dat_d = wr_data;
                vld_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dat_q <= '0;
                vld_q <= 1'b0;
            end else begin
                dat_q <= dat_d;
                vld_q <= vld_d;
            end
        end

        assign pg_data[g] = dat_q;
        assign pg_vld[g]  = vld_q;
    end

endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
    parameter int MEM_AW = 10,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    commit,
    input  logic [MEM_AW-PAGE_W-1:0]                pg_idx,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]      pg_data,
    input  logic [(1<<PAGE_W)-1:0]                  pg_vld,
    input  logic [MEM_AW-1:0]                       rd_addr,
    output logic [DATA_W-1:0]                       rd_data
);

    localparam int NW = 1 << MEM_AW;
    localparam int NB = 1 << PAGE_W;

    logic [DATA_W-1:0] cell_q [NW];

    // Behavioural array: resets to the erased value, commits a page at once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) cell_q[i] <= '1;
        end else if (commit) begin
            for (int b = 0; b < NB; b++) begin
                if (pg_vld[b]) cell_q[{pg_idx, PAGE_W'(b)}] <= pg_data[b];
            end
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 6,
    parameter int MEM_AW   = 10,
    parameter int WIN_CYC  = 12500,
    parameter int PROG_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe
);

    localparam int PGA_W = ADDR_W - PAGE_W;
    localparam int PIX_W = MEM_AW - PAGE_W;
    localparam int NB    = 1 << PAGE_W;
    localparam int WCW   = $clog2(WIN_CYC + 1);
    localparam int PCW   = $clog2(PROG_CYC + 1);
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_CYC - 1);
    localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);

    typedef struct packed {
        pgw_state_e        state;
        logic [WCW-1:0]    win;
        logic [PCW-1:0]    prog;
        logic [PGA_W-1:0]  page;
        logic [PAGE_W-1:0] off;
        logic              acc;
        logic [DATA_W-1:0] dlat;
        logic [DATA_W-1:0] last;
        logic              tog;
        logic [DATA_W-1:0] rdata;
        logic              rd_oe;
    } ctl_t;

    ctl_t q, nx;

    logic wr_lvl, wr_start, wr_end, wr_held, rd_lvl, rd_end;
    logic buf_wr, buf_clr, commit;
    logic [NB-1:0][DATA_W-1:0] pg_data;
    logic [NB-1:0]             pg_vld;
    logic [DATA_W-1:0]         mem_rd;
    logic [DATA_W-1:0]         stat;
    logic [PGA_W-1:0]          wr_page;
    logic                      pg_match;

    pgw_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .oe_n     (bus_oe_n),
        .wr_lvl   (wr_lvl),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .wr_held  (wr_held),
        .rd_lvl   (rd_lvl),
        .rd_end   (rd_end)
    );

    pgw_pagebuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pagebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_off  (q.off),
        .wr_data (q.dlat),
        .clr     (buf_clr),
        .pg_data (pg_data),
        .pg_vld  (pg_vld)
    );

    pgw_store #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .pg_idx  (q.page[PIX_W-1:0]),
        .pg_data (pg_data),
        .pg_vld  (pg_vld),
        .rd_addr (bus_addr[MEM_AW-1:0]),
        .rd_data (mem_rd)
    );

    assign wr_page  = bus_addr[ADDR_W-1:PAGE_W];
    assign pg_match = (wr_page == q.page);

    // Status byte: last loaded byte, top bit inverted, next bit is the toggle.
    always_comb begin
        stat           = q.last;
        stat[DATA_W-1] = ~q.last[DATA_W-1];
        stat[DATA_W-2] = q.tog;
    end

    always_comb begin
        nx      = q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        commit  = 1'b0;

        nx.rd_oe = rd_lvl;
        if (rd_lvl) nx.rdata = (q.state == PGW_PROG) ? stat : mem_rd;
        else        nx.rdata = '0;

        if (wr_lvl) nx.dlat = bus_wdata;

        unique case (q.state)
            PGW_IDLE: begin
                if (wr_start) begin
                    nx.state = PGW_LOAD;
                    nx.page  = wr_page;
                    nx.off   = bus_addr[PAGE_W-1:0];
                    nx.acc   = 1'b1;
                    nx.win   = '0;
                end
            end
            PGW_LOAD: begin
                if (q.win != WIN_LAST) nx.win = q.win + 1'b1;
                if (wr_start) begin
                    if (pg_match) begin
                        nx.off = bus_addr[PAGE_W-1:0];
                        nx.acc = 1'b1;
                        nx.win = '0;
                    end else begin
                        nx.acc = 1'b0;
                    end
                end
                if (wr_end && q.acc) begin
                    buf_wr  = 1'b1;
                    nx.last = q.dlat;
                    nx.acc  = 1'b0;
                end else if ((q.win == WIN_LAST) && !(wr_held && q.acc)
                             && !(wr_start && pg_match)) begin
                    nx.state = PGW_PROG;
                    nx.prog  = '0;
                    nx.acc   = 1'b0;
                end
            end
            PGW_PROG: begin
                nx.prog = q.prog + 1'b1;
                if (rd_end) nx.tog = ~q.tog;
                if (q.prog == PROG_LAST) begin
                    commit   = 1'b1;
                    buf_clr  = 1'b1;
                    nx.state = PGW_IDLE;
                end
            end
            default: nx.state = PGW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nx;
    end

    assign bus_rdata    = q.rdata;
    assign bus_rdata_oe = q.rd_oe;

    // Named views of state for the bound checker.
    pgw_state_e        chk_state;
    logic              chk_tog;
    logic [DATA_W-1:0] chk_last;
    assign chk_state = q.state;
    assign chk_tog   = q.tog;
    assign chk_last  = q.last;

endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk
    import pgw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ce_n,
    input logic              bus_we_n,
    input logic              bus_oe_n,
    input logic              bus_rdata_oe,
    input pgw_state_e        state,
    input logic              tog,
    input logic [DATA_W-1:0] last
);

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_n && !bus_we_n) |=> !bus_rdata_oe); // R1

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_n && !bus_oe_n && bus_we_n) |=> bus_rdata_oe); // R1

    AST_DESELECT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_n |=> !bus_rdata_oe); // R1

    AST_PROG_ONLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PGW_IDLE) |=> (state != PGW_PROG)); // R5

    AST_PROG_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PGW_PROG) |=> (state != PGW_LOAD)); // R8

    AST_STATUS_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PGW_PROG) |=> $stable(last)); // R8

    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PGW_PROG) |=> $stable(tog)); // R7

endmodule

bind pgw_ctrl pgw_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ce_n     (bus_ce_n),
    .bus_we_n     (bus_we_n),
    .bus_oe_n     (bus_oe_n),
    .bus_rdata_oe (bus_rdata_oe),
    .state        (chk_state),
    .tog          (chk_tog),
    .last         (chk_last)
);

// File: tb/pgw_ctrl_test.sv
module pgw_ctrl_test;

    localparam int WIN  = 8;
    localparam int PROG = 20;

    typedef struct packed {
        logic [12:0] a;
        logic [7:0]  d;
        logic [3:0]  gap;
        logic [7:0]  exp;
    } vec_t;

    // Page loads: address, data, idle cycles before next load, expected readback.
    localparam vec_t VT [5] = '{
        '{a: 13'h0A45, d: 8'h3C, gap: 4'd0, exp: 8'h9E},
        '{a: 13'h0A7F, d: 8'h81, gap: 4'd3, exp: 8'h81},
        '{a: 13'h0A40, d: 8'h00, gap: 4'd6, exp: 8'h00},
        '{a: 13'h0A52, d: 8'hC7, gap: 4'd1, exp: 8'hC7},
        '{a: 13'h0A45, d: 8'h9E, gap: 4'd0, exp: 8'h9E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;

    int n = 0;
    int last_start = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgw_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ce_n     (ce_n),
        .bus_we_n     (we_n),
        .bus_oe_n     (oe_n),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .bus_rdata_oe (rdata_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic wait_to(input int idx);
        while (n < idx) step();
    endtask

    task automatic do_load(input logic [12:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        last_start = n + 1;
        step();
        ce_n = 1'b1; we_n = 1'b1;
        step();
    endtask

    task automatic do_read(input logic [12:0] a, output logic [7:0] v, output logic o);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        step();
        v = rdata; o = rdata_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    initial begin
        logic [7:0] v, v2;
        logic       o;
        int         e;

        // Reset state
        step(); step();
        check(rdata_oe == 1'b0, "R9 reset oe", rdata_oe, 0);
        rst_n = 1'b1;
        step();
        do_read(13'h0123, v, o);
        check(v == 8'hFF, "R9 erased read", v, 8'hFF);
        check(o == 1'b1, "R1 read drives bus", o, 1);

        // Table walk: a page load with varied gaps, window boundary included (R4)
        for (int i = 0; i < 5; i++) begin
            do_load(VT[i].a, VT[i].d);
            repeat (VT[i].gap) step();
        end
        e = last_start;
        wait_to(e + WIN - 1);
        do_read(13'h0100, v, o);
        check(v == 8'hFF, "R5 no programming before window ends", v, 8'hFF);
        wait_to(e + WIN + 1);
        do_read(13'h0100, v, o);
        check((v & 8'hBF) == 8'h1E, "R6 status byte", v & 8'hBF, 8'h1E);
        wait_to(e + WIN + 3);
        do_read(13'h0100, v2, o);
        check(v2[6] != v[6], "R7 toggle inverts", v2[6], ~v[6]);
        check((v2 & 8'hBF) == 8'h1E, "R6 status repeat", v2 & 8'hBF, 8'h1E);
        wait_to(e + WIN + 5);
        do_load(13'h0A41, 8'h11);
        do_load(13'h0301, 8'h22);
        wait_to(e + WIN + PROG - 1);
        do_read(13'h0A45, v, o);
        check((v & 8'hBF) == 8'h1E, "R6 status on last programming cycle", v & 8'hBF, 8'h1E);
        do_read(13'h0A45, v, o);
        check(v == 8'h9E, "R9 true data after programming", v, 8'h9E);
        do_read(13'h0A45, v2, o);
        check(v2 == v, "R7 no toggling when idle", v2, v);
        for (int i = 0; i < 5; i++) begin
            do_read(VT[i].a, v, o);
            check(v == VT[i].exp, "R4 page byte readback", v, VT[i].exp);
        end
        do_read(13'h0A41, v, o);
        check(v == 8'hFF, "R8 load during programming ignored", v, 8'hFF);
        do_read(13'h0301, v, o);
        check(v == 8'hFF, "R8 other-page load during programming ignored", v, 8'hFF);
        do_read(13'h0A46, v, o);
        check(v == 8'hFF, "R5 unloaded offset unchanged", v, 8'hFF);

        // Page mismatch: ignored, window not restarted (R3)
        do_load(13'h01C3, 8'h42);
        e = last_start;
        do_load(13'h0203, 8'h99);
        wait_to(e + WIN);
        do_read(13'h01C3, v, o);
        check((v & 8'hBF) == 8'h82, "R3 window not restarted by mismatch", v & 8'hBF, 8'h82);
        wait_to(e + WIN + PROG + 2);
        do_read(13'h0203, v, o);
        check(v == 8'hFF, "R3 mismatched load not written", v, 8'hFF);
        do_read(13'h01C3, v, o);
        check(v == 8'h42, "R3 first page byte written", v, 8'h42);

        // Non-write strobe combinations (R1)
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 13'h0055; wdata = 8'h5A;
        step();
        check(rdata_oe == 1'b0, "R1 no drive with both strobes", rdata_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1; addr = 13'h0056; wdata = 8'h5B;
        step();
        check(rdata_oe == 1'b0, "R1 no drive when deselected", rdata_oe, 0);
        we_n = 1'b1;
        repeat (WIN + PROG + 4) step();
        do_read(13'h0055, v, o);
        check(v == 8'hFF, "R1 read strobe blocks write", v, 8'hFF);
        do_read(13'h0056, v, o);
        check(v == 8'hFF, "R1 deselect blocks write", v, 8'hFF);

        // Address from first cycle, data from last cycle; overwrite without erase
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 13'h0A45; wdata = 8'h00;
        e = n + 1;
        step();
        addr = 13'h0A46; wdata = 8'h61;
        step();
        ce_n = 1'b1; we_n = 1'b1;
        step();
        wait_to(e + WIN + PROG + 2);
        do_read(13'h0A45, v, o);
        check(v == 8'h61, "R2 data from last cycle at first address", v, 8'h61);
        check(v == 8'h61, "R10 9E overwritten with 61", v, 8'h61);
        do_read(13'h0A46, v, o);
        check(v == 8'hFF, "R2 later address ignored", v, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule